// File: doc/BRIEF.md
# Interrupt Request Priority Cell Array

This block holds the per-level request state of a priority interrupt controller. It is built from one cell for each request level. Each cell holds a request bit, a mask bit and an in-service bit. It also keeps edge-sense state for its request line. The block sits between the raw request lines and a separate priority resolver. It gives the resolver a vector of unmasked pending requests and takes back per-level strobes that mark a level as in service or finished.

Each request line first passes through a multi-flop synchronizer. A global sense-mode input selects how the request is captured:

- **Edge mode:** a low-to-high transition arms the request, and the line must stay high to keep it.
- **Level mode:** the request follows the synchronized line directly.

While the freeze input is high, as it is during acknowledge and poll sequences, the request bits hold their value. Masking is applied only after the request register, so a masked request still shows in the request vector.

A master clear input is driven while the controller is being initialized. It wipes all request, mask, in-service and edge-sense state.

Top module: `irq_cell_array`

## Requirements
- R1: After reset (rst_ni low), irr_o, imr_o, isr_o and req_o are all zero.
- R2: A request line held high in level mode (level_mode_i=1) appears in irr_o exactly three rising clock edges after it is applied (two synchronizer flops plus the request register). It disappears the same way when the line drops.
- R3: In edge mode (level_mode_i=0), a request is captured on a low-to-high transition. Once that level is acknowledged, the still-high line raises no new request until it has gone low and then high again.
- R4: In level mode, a line still high after acknowledge sets its irr_o bit again on the next clock edge, provided freeze is low.
- R5: While freeze_i is 1, no irr_o bit changes except by an acknowledge strobe or master clear. On release, irr_o follows the current request inputs on the next edge.
- R6: Bit i of req_o equals irr_o[i] AND NOT imr_o[i]. The mask never alters irr_o.
- R7: A cycle with mask_we_i=1 loads mask_wdata_i into imr_o on the next edge. Bit i masks level i.
- R8: isr_set_i[i] sets isr_o[i] and clears irr_o[i] and the level's edge-sense state on the next edge, even while freeze_i is 1.
- R9: isr_clr_i[i] clears isr_o[i]. If isr_set_i[i] and isr_clr_i[i] are high in the same cycle, the bit ends up set.
- R10: mclr_i clears irr_o, imr_o, isr_o and the edge-sense state on the next edge, overriding mask writes and strobes. In edge mode, a line held high across the clear raises no request afterwards.
- R11: In edge mode, a captured request whose line goes low before it is acknowledged is removed from irr_o when freeze is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_LEVELS | Asynchronous request lines, bit i is level i |
| level_mode_i | input | 1 | 1 = level sensing, 0 = edge sensing |
| freeze_i | input | 1 | Holds the request register during acknowledge or poll |
| mclr_i | input | 1 | Master clear during initialization |
| mask_we_i | input | 1 | Mask register write enable |
| mask_wdata_i | input | NUM_LEVELS | Mask write data, 1 masks the level |
| isr_set_i | input | NUM_LEVELS | Per-level acknowledge strobe from the resolver |
| isr_clr_i | input | NUM_LEVELS | Per-level end-of-interrupt strobe |
| irr_o | output | NUM_LEVELS | Request register |
| imr_o | output | NUM_LEVELS | Mask register |
| isr_o | output | NUM_LEVELS | In-service register |
| req_o | output | NUM_LEVELS | Unmasked requests to the priority resolver |

## Verification
The assertions check these rules on every cycle:

- the request bit holds under freeze when no acknowledge or clear is present;
- an acknowledge sets the in-service bit and drops the request;
- end-of-interrupt clears the in-service bit;
- mask writes load the mask;
- master clear empties all three registers;
- no masked level reaches req_o.

Only the bench scenarios can show the behaviours that depend on history. These are:

- the exact three-edge synchronizer latency;
- the edge re-arm rule after acknowledge and after master clear;
- the level-mode re-request after acknowledge;
- request removal when an edge-mode line falls early;
- the release of freeze onto new request inputs.

// File: rtl/irq_cell_pkg.sv
package irq_cell_pkg;
  localparam int unsigned DEF_LEVELS = 8;
  localparam int unsigned DEF_SYNC   = 2;

  typedef enum logic {
    SENSE_EDGE  = 1'b0,
    SENSE_LEVEL = 1'b1
  } sense_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_cell.sv
module irq_cell
  import irq_cell_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ir_i,
  input  logic level_mode_i,
  input  logic freeze_i,
  input  logic mclr_i,
  input  logic mask_we_i,
  input  logic mask_d_i,
  input  logic isr_set_i,
  input  logic isr_clr_i,
  output logic irr_o,
  output logic imr_o,
  output logic isr_o,
  output logic req_o
);
  sense_e sense;
  logic   ir_prev_q, armed_q, irr_q, imr_q, isr_q;
  logic   rise, edge_req, req_in;

  assign sense    = sense_e'(level_mode_i);
  assign rise     = ir_i & ~ir_prev_q;
  assign edge_req = ir_i & (armed_q | rise);
  assign req_in   = (sense == SENSE_LEVEL) ? ir_i : edge_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ir_prev_q <= 1'b0;
    else         ir_prev_q <= ir_i;
  end

  // edge-sense latch: armed by a rising edge, dropped by low line, ack or clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  armed_q <= 1'b0;
    else if (mclr_i || isr_set_i) armed_q <= 1'b0;
    else if (!ir_i)               armed_q <= 1'b0;
    else if (rise)                armed_q <= 1'b1;
  end

  // request latch modeled as clock-enabled register, enable = !freeze
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  irr_q <= 1'b0;
    else if (mclr_i || isr_set_i) irr_q <= 1'b0;
    else if (!freeze_i)           irr_q <= req_in;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        imr_q <= 1'b0;
    else if (mclr_i)    imr_q <= 1'b0;
    else if (mask_we_i) imr_q <= mask_d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        isr_q <= 1'b0;
    else if (mclr_i)    isr_q <= 1'b0;
    else if (isr_set_i) isr_q <= 1'b1;
    else if (isr_clr_i) isr_q <= 1'b0;
  end

  assign irr_o = irr_q;
  assign imr_o = imr_q;
  assign isr_o = isr_q;
  assign req_o = irr_q & ~imr_q;

  a_r5_freeze_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !mclr_i && !isr_set_i) |=> $stable(irr_q))
    else $error("R5 request changed under freeze");

  a_r8_ack_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_set_i && !mclr_i) |=> (isr_q && !irr_q && !armed_q))
    else $error("R8 acknowledge did not take");

  a_r9_eoi_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_clr_i && !isr_set_i && !mclr_i) |=> !isr_q)
    else $error("R9 end of interrupt ignored");

  a_r7_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_we_i && !mclr_i) |=> (imr_q == $past(mask_d_i)))
    else $error("R7 mask not loaded");

  a_r3_armed_needs_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> $past(ir_i))
    else $error("R3 edge latch armed without line high");
endmodule

// File: rtl/irq_cell_array.sv
module irq_cell_array
  import irq_cell_pkg::*;
#(
  parameter int unsigned NUM_LEVELS  = DEF_LEVELS,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_LEVELS-1:0] irq_i,
  input  logic                  level_mode_i,
  input  logic                  freeze_i,
  input  logic                  mclr_i,
  input  logic                  mask_we_i,
  input  logic [NUM_LEVELS-1:0] mask_wdata_i,
  input  logic [NUM_LEVELS-1:0] isr_set_i,
  input  logic [NUM_LEVELS-1:0] isr_clr_i,
  output logic [NUM_LEVELS-1:0] irr_o,
  output logic [NUM_LEVELS-1:0] imr_o,
  output logic [NUM_LEVELS-1:0] isr_o,
  output logic [NUM_LEVELS-1:0] req_o
);
  localparam int unsigned LVL_W = NUM_LEVELS;

  logic [LVL_W-1:0] ir_sync;

  irq_sync #(
    .WIDTH (LVL_W),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .q_o   (ir_sync)
  );

  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_cell
    irq_cell u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ir_i        (ir_sync[i]),
      .level_mode_i(level_mode_i),
      .freeze_i    (freeze_i),
      .mclr_i      (mclr_i),
      .mask_we_i   (mask_we_i),
      .mask_d_i    (mask_wdata_i[i]),
      .isr_set_i   (isr_set_i[i]),
      .isr_clr_i   (isr_clr_i[i]),
      .irr_o       (irr_o[i]),
      .imr_o       (imr_o[i]),
      .isr_o       (isr_o[i]),
      .req_o       (req_o[i])
    );
  end

  a_r10_master_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclr_i |=> (irr_o == '0 && imr_o == '0 && isr_o == '0))
    else $error("R10 master clear left state");

  a_r6_no_masked_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o & imr_o) == '0)
    else $error("R6 masked level reached resolver");
endmodule

// File: tb/tb_irq_cell_array.sv
module tb_irq_cell_array;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq = '0, mask_wd = '0, iset = '0, iclr = '0;
  logic lvl = 1'b1, frz = 1'b0, mclr = 1'b0, mwe = 1'b0;
  logic [N-1:0] irr, imr, isr, req;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  irq_cell_array #(.NUM_LEVELS(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .level_mode_i(lvl),
    .freeze_i(frz), .mclr_i(mclr), .mask_we_i(mwe), .mask_wdata_i(mask_wd),
    .isr_set_i(iset), .isr_clr_i(iclr),
    .irr_o(irr), .imr_o(imr), .isr_o(isr), .req_o(req)
  );

  // {level, irq, mask, exp_irr, exp_req}
  localparam int NV = 8;
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 8'h05, 8'h00, 8'h05, 8'h05},
    {1'b1, 8'h05, 8'h04, 8'h05, 8'h01},
    {1'b1, 8'hF0, 8'h30, 8'hF0, 8'hC0},
    {1'b1, 8'h00, 8'hFF, 8'h00, 8'h00},
    {1'b0, 8'h81, 8'h00, 8'h81, 8'h81},
    {1'b0, 8'h81, 8'h01, 8'h81, 8'h80},
    {1'b0, 8'h80, 8'h00, 8'h80, 8'h80},
    {1'b1, 8'hAA, 8'h0F, 8'hAA, 8'hA0}
  };

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic write_mask(input logic [N-1:0] m);
    mwe = 1'b1; mask_wd = m;
    clocks(1);
    mwe = 1'b0;
  endtask

  task automatic pulse_set(input logic [N-1:0] s);
    iset = s; clocks(1); iset = '0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clocks(2);
    // R1 reset state
    chk("R1 irr", irr, '0); chk("R1 imr", imr, '0);
    chk("R1 isr", isr, '0); chk("R1 req", req, '0);
    rst_n = 1'b1;
    clocks(1);

    // table walk: R6 R7 and mode behaviour
    for (int v = 0; v < NV; v++) begin
      lvl = VEC[v][32];
      irq = VEC[v][31:24];
      write_mask(VEC[v][23:16]);
      clocks(4);
      chk($sformatf("R7 vec%0d imr", v), imr, VEC[v][23:16]);
      chk($sformatf("R6 vec%0d irr", v), irr, VEC[v][15:8]);
      chk($sformatf("R6 vec%0d req", v), req, VEC[v][7:0]);
    end
    irq = '0; write_mask('0); clocks(4);

    // R2 latency
    lvl = 1'b1; irq = 8'h10;
    clocks(2); chk("R2 before third edge", irr, 8'h00);
    clocks(1); chk("R2 third edge", irr, 8'h10);
    irq = '0;
    clocks(2); chk("R2 hold two edges", irr, 8'h10);
    clocks(1); chk("R2 drop third edge", irr, 8'h00);

    // R3 edge re-arm
    lvl = 1'b0; irq = 8'h02; clocks(4);
    chk("R3 edge captured", irr, 8'h02);
    pulse_set(8'h02);
    chk("R8 isr set", isr, 8'h02);
    chk("R8 irr cleared", irr, 8'h00);
    clocks(4); chk("R3 no rearm while high", irr, 8'h00);
    irq = '0; clocks(4); irq = 8'h02; clocks(4);
    chk("R3 rearm after low-high", irr, 8'h02);
    iclr = 8'h02; clocks(1); iclr = '0;
    chk("R9 eoi clears", isr, 8'h00);
    irq = '0; clocks(4);

    // R4 level re-request
    lvl = 1'b1; irq = 8'h04; clocks(4);
    pulse_set(8'h04);
    chk("R8 level ack irr", irr, 8'h00);
    clocks(1); chk("R4 level re-request", irr, 8'h04);
    iclr = 8'h04; clocks(1); iclr = '0;
    irq = '0; clocks(4);

    // R5 freeze, R8 ack under freeze
    irq = 8'h08; clocks(4);
    frz = 1'b1; irq = 8'h48; clocks(5);
    chk("R5 frozen hold", irr, 8'h08);
    pulse_set(8'h08);
    chk("R8 ack under freeze irr", irr, 8'h00);
    chk("R8 ack under freeze isr", isr, 8'h08);
    clocks(3); chk("R5 frozen after ack", irr, 8'h00);
    frz = 1'b0; clocks(1);
    chk("R5 release follows inputs", irr, 8'h48);

    // R9 simultaneous set and clear
    iclr = 8'h08; iset = 8'h40; clocks(1);
    iclr = 8'h40; iset = 8'h40; clocks(1);
    iclr = '0; iset = '0;
    chk("R9 set wins and eoi", isr, 8'h40);
    irq = '0; clocks(4);

    // R10 master clear
    lvl = 1'b0; irq = 8'h01; clocks(4);
    write_mask(8'hF0);
    chk("R10 pre irr", irr, 8'h01);
    mclr = 1'b1; mwe = 1'b1; mask_wd = 8'h55; iset = 8'h80;
    clocks(1);
    mclr = 1'b0; mwe = 1'b0; iset = '0;
    chk("R10 irr", irr, 8'h00); chk("R10 imr", imr, 8'h00);
    chk("R10 isr", isr, 8'h00);
    clocks(4); chk("R10 held line no request", irr, 8'h00);
    irq = '0; clocks(4);

    // R11 edge request withdrawn
    irq = 8'h20; clocks(4); chk("R11 captured", irr, 8'h20);
    irq = '0; clocks(4); chk("R11 withdrawn", irr, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule